// File: doc/BRIEF.md
# Per-CTA Live Thread Tally

This block keeps two thread counters for each of a small, fixed number of thread-array (CTA) slots. The first counter, *remaining*, starts at the CTA's thread count when the CTA is started and drops by one warp's worth of threads each time a whole warp finishes. The second counter, *alive*, starts at zero and tracks the threads that have been launched and have not yet exited. It rises by one warp's worth on each warp launch and falls by the same amount on each warp exit. Both counters move only in whole-warp steps of 32. When a CTA's size is not a multiple of 32, they therefore differ from the exact thread count.

Start, warp-launch, warp-completion and warp-exit events arrive as single-cycle strobes, each tagged with a slot index. Several event kinds may target the same or different slots in the same cycle. A read port selects one slot and presents its two counters, a flag showing that the slot has been started, and a sticky underflow flag. Updates take effect at the clock edge that samples the event. The read path is combinational from the stored state.

Top module: `cta_thread_tally`

## Requirements
- R1: After reset every slot reads remaining = 0, alive = 0, loaded = 0 and underflow = 0.
- R2: A start event on a slot loads remaining with the supplied thread count, clears alive to 0, sets loaded to 1 and clears underflow. The new values are visible from the cycle after the sampling edge.
- R3: A warp-done event with the whole-warp qualifier set subtracts 32 from the slot's remaining counter.
- R4: A warp-done event with the whole-warp qualifier clear leaves remaining unchanged.
- R5: A warp-launch event adds 32 to the slot's alive counter. The result saturates at 8191, the largest 13-bit value.
- R6: A warp-exit event subtracts 32 from the slot's alive counter.
- R7: A warp-launch and a warp-exit on the same slot in the same cycle cancel, and alive keeps its value.
- R8: A subtraction that would take either counter below zero leaves that counter at 0 and sets the slot's underflow flag. The flag stays set until the next start event on that slot.
- R9: While a slot has not been started, warp events addressed to it are ignored. Its counters stay at 0 and its underflow flag stays at 0.
- R10: When a start event and any warp event hit the same slot in one cycle, the start event wins and the warp events are dropped.
- R11: Events addressed to one slot never change another slot's state.
- R12: The read outputs follow the read-slot select combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cta_start | input | 1 | Start strobe for a CTA slot |
| cta_start_slot | input | SLOT_W | Slot being started |
| cta_start_threads | input | CNT_W | Thread count of the starting CTA |
| warp_go | input | 1 | Warp-launch strobe |
| warp_go_slot | input | SLOT_W | Slot of the launched warp |
| warp_done | input | 1 | Warp-completion strobe |
| warp_done_whole | input | 1 | 1 when every thread of the warp completed |
| warp_done_slot | input | SLOT_W | Slot of the completing warp |
| warp_quit | input | 1 | Warp-exit strobe |
| warp_quit_slot | input | SLOT_W | Slot of the exiting warp |
| view_slot | input | SLOT_W | Slot selected for reading |
| view_remaining | output | CNT_W | Remaining-thread counter of the selected slot |
| view_alive | output | CNT_W | Launched-alive counter of the selected slot |
| view_loaded | output | 1 | Selected slot has been started |
| view_underflow | output | 1 | Sticky underflow flag of the selected slot |

## Verification
Every piece of per-slot state is visible through the read port one edge after the event that changes it. A wrong step size, a missed cancel, a wrap instead of saturation, or an event that leaks into a neighbouring slot therefore shows up on the very next read of that slot. The stimulus reads the targeted slot after each event, and it also rereads the untouched slots. This catches a stuck or cross-wired slot decode, and it catches a lost sticky flag even when the fault only appears several events later.

// File: rtl/cta_tally_pkg.sv
package cta_tally_pkg;

  // Per-slot event bundle produced by the decoder, consumed by a slot tally.
  typedef struct packed {
    logic load;        // CTA start on this slot
    logic up;          // warp launch
    logic down_rem;    // whole-warp completion
    logic down_alive;  // warp exit
  } slot_evt_t;

  localparam int unsigned WARP_THREADS = 32;

endpackage

// File: rtl/cta_evt_decode.sv
module cta_evt_decode
  import cta_tally_pkg::*;
#(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned SLOT_W = 2
) (
  input  logic                          start_v,
  input  logic [SLOT_W-1:0]             start_slot,
  input  logic                          go_v,
  input  logic [SLOT_W-1:0]             go_slot,
  input  logic                          done_v,
  input  logic                          done_whole,
  input  logic [SLOT_W-1:0]             done_slot,
  input  logic                          quit_v,
  input  logic [SLOT_W-1:0]             quit_slot,
  output slot_evt_t [SLOTS-1:0]         evt_o
);

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
    always_comb begin
      evt_o[gi].load       = start_v && (start_slot == SLOT_W'(gi));
      evt_o[gi].up         = go_v && (go_slot == SLOT_W'(gi));
      evt_o[gi].down_rem   = done_v && done_whole && (done_slot == SLOT_W'(gi));
      evt_o[gi].down_alive = quit_v && (quit_slot == SLOT_W'(gi));
    end
  end

endmodule

// File: rtl/cta_slot_tally.sv
module cta_slot_tally
  import cta_tally_pkg::*;
#(
  parameter int unsigned CNT_W = 13,
  parameter int unsigned STEP  = WARP_THREADS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_evt_t        evt,
  input  logic [CNT_W-1:0] load_count,
  output logic [CNT_W-1:0] remaining,
  output logic [CNT_W-1:0] alive,
  output logic             loaded,
  output logic             underflow
);

  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);
  localparam logic [CNT_W-1:0] MAX_V  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] rem_q, rem_d;
  logic [CNT_W-1:0] al_q, al_d;
  logic             st_q, st_d;
  logic             uf_q, uf_d;
  logic             upd_en;

  // Next-state logic
  always_comb begin
    rem_d  = rem_q;
    al_d   = al_q;
    st_d   = st_q;
    uf_d   = uf_q;
    upd_en = evt.load | (st_q & (evt.up | evt.down_rem | evt.down_alive));
    if (evt.load) begin
      rem_d = load_count;
      al_d  = '0;
      st_d  = 1'b1;
      uf_d  = 1'b0;
    end else if (st_q) begin
      if (evt.down_rem) begin
        if (rem_q < STEP_V) begin
          rem_d = '0;
          uf_d  = 1'b1;
        end else begin
          rem_d = rem_q - STEP_V;
        end
      end
      if (evt.up && !evt.down_alive) begin
        al_d = (al_q > (MAX_V - STEP_V)) ? MAX_V : (al_q + STEP_V);
      end else if (evt.down_alive && !evt.up) begin
        if (al_q < STEP_V) begin
          al_d = '0;
          uf_d = 1'b1;
        end else begin
          al_d = al_q - STEP_V;
        end
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      al_q  <= '0;
      st_q  <= 1'b0;
      uf_q  <= 1'b0;
    end else if (upd_en) begin
      rem_q <= rem_d;
      al_q  <= al_d;
      st_q  <= st_d;
      uf_q  <= uf_d;
    end
  end

  assign remaining = rem_q;
  assign alive     = al_q;
  assign loaded    = st_q;
  assign underflow = uf_q;

  // Unstarted slots hold zero state (R9)
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !st_q |-> (rem_q == '0 && al_q == '0 && !uf_q));

  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt.load |=> (rem_q == $past(load_count) && al_q == '0 && st_q && !uf_q));

  assert_remain_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q && !evt.load && evt.down_rem && rem_q >= STEP_V)
      |=> (rem_q == $past(rem_q) - STEP_V));

  assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q && !evt.load && evt.up && evt.down_alive) |=> $stable(al_q));

  assert_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q && !evt.load && evt.down_rem && rem_q < STEP_V) |=> (rem_q == '0 && uf_q));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_q && !evt.load) |=> uf_q);

endmodule

// File: rtl/cta_read_sel.sv
module cta_read_sel #(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned SLOT_W = 2,
  parameter int unsigned CNT_W  = 13
) (
  input  logic [SLOT_W-1:0]             sel,
  input  logic [SLOTS-1:0][CNT_W-1:0]   rem_all,
  input  logic [SLOTS-1:0][CNT_W-1:0]   al_all,
  input  logic [SLOTS-1:0]              st_all,
  input  logic [SLOTS-1:0]              uf_all,
  output logic [CNT_W-1:0]              rem_o,
  output logic [CNT_W-1:0]              al_o,
  output logic                          st_o,
  output logic                          uf_o
);

  localparam logic [SLOT_W:0] SLOTS_V = (SLOT_W+1)'(SLOTS);

  logic in_range;
  assign in_range = ({1'b0, sel} < SLOTS_V);

  always_comb begin
    rem_o = '0;
    al_o  = '0;
    st_o  = 1'b0;
    uf_o  = 1'b0;
    if (in_range) begin
      rem_o = rem_all[sel];
      al_o  = al_all[sel];
      st_o  = st_all[sel];
      uf_o  = uf_all[sel];
    end
  end

endmodule

// File: rtl/cta_thread_tally.sv
module cta_thread_tally
  import cta_tally_pkg::*;
#(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned CNT_W  = 13,
  parameter int unsigned STEP   = WARP_THREADS,
  parameter int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cta_start,
  input  logic [SLOT_W-1:0] cta_start_slot,
  input  logic [CNT_W-1:0]  cta_start_threads,
  input  logic              warp_go,
  input  logic [SLOT_W-1:0] warp_go_slot,
  input  logic              warp_done,
  input  logic              warp_done_whole,
  input  logic [SLOT_W-1:0] warp_done_slot,
  input  logic              warp_quit,
  input  logic [SLOT_W-1:0] warp_quit_slot,
  input  logic [SLOT_W-1:0] view_slot,
  output logic [CNT_W-1:0]  view_remaining,
  output logic [CNT_W-1:0]  view_alive,
  output logic              view_loaded,
  output logic              view_underflow
);

  slot_evt_t [SLOTS-1:0]       evt;
  logic [SLOTS-1:0][CNT_W-1:0] rem_all;
  logic [SLOTS-1:0][CNT_W-1:0] al_all;
  logic [SLOTS-1:0]            st_all;
  logic [SLOTS-1:0]            uf_all;

  cta_evt_decode #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_decode (
    .start_v    (cta_start),
    .start_slot (cta_start_slot),
    .go_v       (warp_go),
    .go_slot    (warp_go_slot),
    .done_v     (warp_done),
    .done_whole (warp_done_whole),
    .done_slot  (warp_done_slot),
    .quit_v     (warp_quit),
    .quit_slot  (warp_quit_slot),
    .evt_o      (evt)
  );

  for (genvar gs = 0; gs < SLOTS; gs++) begin : g_tally
    cta_slot_tally #(.CNT_W(CNT_W), .STEP(STEP)) u_tally (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt[gs]),
      .load_count (cta_start_threads),
      .remaining  (rem_all[gs]),
      .alive      (al_all[gs]),
      .loaded     (st_all[gs]),
      .underflow  (uf_all[gs])
    );
  end

  cta_read_sel #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_read (
    .sel     (view_slot),
    .rem_all (rem_all),
    .al_all  (al_all),
    .st_all  (st_all),
    .uf_all  (uf_all),
    .rem_o   (view_remaining),
    .al_o    (view_alive),
    .st_o    (view_loaded),
    .uf_o    (view_underflow)
  );

  // A slot that has not been started never reports underflow (R9)
  assert_unloaded_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !view_loaded |-> !view_underflow);

endmodule

// File: tb/cta_thread_tally_tb.sv
module cta_thread_tally_tb;

  localparam int SLOTS = 4;
  localparam int CW    = 13;
  localparam int SW    = 2;

  logic          clk;
  logic          rst_n;
  logic          cta_start;
  logic [SW-1:0] cta_start_slot;
  logic [CW-1:0] cta_start_threads;
  logic          warp_go;
  logic [SW-1:0] warp_go_slot;
  logic          warp_done;
  logic          warp_done_whole;
  logic [SW-1:0] warp_done_slot;
  logic          warp_quit;
  logic [SW-1:0] warp_quit_slot;
  logic [SW-1:0] view_slot;
  logic [CW-1:0] view_remaining;
  logic [CW-1:0] view_alive;
  logic          view_loaded;
  logic          view_underflow;

  int checks;
  int errors;

  cta_thread_tally u_dut (
    .clk(clk), .rst_n(rst_n),
    .cta_start(cta_start), .cta_start_slot(cta_start_slot),
    .cta_start_threads(cta_start_threads),
    .warp_go(warp_go), .warp_go_slot(warp_go_slot),
    .warp_done(warp_done), .warp_done_whole(warp_done_whole),
    .warp_done_slot(warp_done_slot),
    .warp_quit(warp_quit), .warp_quit_slot(warp_quit_slot),
    .view_slot(view_slot), .view_remaining(view_remaining),
    .view_alive(view_alive), .view_loaded(view_loaded),
    .view_underflow(view_underflow)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  typedef struct packed {
    logic          ld;  logic [SW-1:0] ls;  logic [CW-1:0] lc;
    logic          wl;  logic [SW-1:0] wls;
    logic          wd;  logic          wdf; logic [SW-1:0] wds;
    logic          we;  logic [SW-1:0] wes;
    logic [SW-1:0] rs;
    logic [CW-1:0] erem; logic [CW-1:0] eal; logic eld; logic euf;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1,0,100, 0,0, 0,0,0, 0,0, 0, 100, 0,1,0, 2},  // R2 start slot0
    '{0,0,0,   1,0, 0,0,0, 0,0, 0, 100,32,1,0, 5},  // R5 launch
    '{0,0,0,   1,0, 0,0,0, 0,0, 0, 100,64,1,0, 5},  // R5 launch
    '{0,0,0,   0,0, 1,1,0, 0,0, 0,  68,64,1,0, 3},  // R3 whole warp done
    '{0,0,0,   0,0, 1,0,0, 0,0, 0,  68,64,1,0, 4},  // R4 partial warp done
    '{0,0,0,   0,0, 0,0,0, 1,0, 0,  68,32,1,0, 6},  // R6 exit
    '{0,0,0,   1,0, 0,0,0, 1,0, 0,  68,32,1,0, 7},  // R7 launch+exit cancel
    '{0,0,0,   0,0, 1,1,0, 0,0, 0,  36,32,1,0, 3},  // R3
    '{0,0,0,   0,0, 1,1,0, 0,0, 0,   4,32,1,0, 3},  // R3
    '{0,0,0,   0,0, 1,1,0, 0,0, 0,   0,32,1,1, 8},  // R8 remaining floor
    '{0,0,0,   1,0, 0,0,0, 0,0, 0,   0,64,1,1, 8},  // R8 sticky
    '{1,1,64,  0,0, 0,0,0, 0,0, 1,  64, 0,1,0, 2},  // R2 start slot1
    '{0,0,0,   0,0, 0,0,0, 1,1, 1,  64, 0,1,1, 8},  // R8 alive floor
    '{0,0,0,   1,2, 1,1,2, 1,3, 2,   0, 0,0,0, 9},  // R9 unstarted slot2
    '{0,0,0,   0,0, 0,0,0, 0,0, 3,   0, 0,0,0, 9},  // R9 unstarted slot3
    '{0,0,0,   0,0, 0,0,0, 0,0, 0,   0,64,1,1,11},  // R11 slot0 untouched
    '{1,0,200, 1,0, 1,1,0, 1,0, 0, 200, 0,1,0,10},  // R10 start wins
    '{1,3,31,  0,0, 0,0,0, 0,0, 3,  31, 0,1,0, 2},  // R2 start slot3
    '{0,0,0,   0,0, 1,1,3, 0,0, 3,   0, 0,1,1, 8}   // R8 floor from 31
  };

  task automatic idle_inputs();
    cta_start = 0; cta_start_slot = 0; cta_start_threads = 0;
    warp_go = 0; warp_go_slot = 0;
    warp_done = 0; warp_done_whole = 0; warp_done_slot = 0;
    warp_quit = 0; warp_quit_slot = 0;
  endtask

  task automatic check(input string req, input logic [CW-1:0] erem,
                       input logic [CW-1:0] eal, input logic eld, input logic euf);
    checks++;
    if (view_remaining !== erem || view_alive !== eal ||
        view_loaded !== eld || view_underflow !== euf) begin
      errors++;
      $display("FAIL %s slot%0d: got rem=%0d alive=%0d loaded=%0b uf=%0b exp rem=%0d alive=%0d loaded=%0b uf=%0b",
               req, view_slot, view_remaining, view_alive, view_loaded, view_underflow,
               erem, eal, eld, euf);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic step();
    @(negedge clk);
  endtask

  task automatic reset_and_check_r1();
    rst_n = 1'b0;
    idle_inputs();
    view_slot = 0;
    repeat (2) step();
    rst_n = 1'b1;
    step();
    for (int s = 0; s < SLOTS; s++) begin
      view_slot = SW'(s);
      #1;
      check("R1", 0, 0, 0, 0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    checks = 0;
    errors = 0;
    reset_and_check_r1();

    for (int i = 0; i < NV; i++) begin
      cta_start = VEC[i].ld; cta_start_slot = VEC[i].ls; cta_start_threads = VEC[i].lc;
      warp_go = VEC[i].wl; warp_go_slot = VEC[i].wls;
      warp_done = VEC[i].wd; warp_done_whole = VEC[i].wdf; warp_done_slot = VEC[i].wds;
      warp_quit = VEC[i].we; warp_quit_slot = VEC[i].wes;
      view_slot = VEC[i].rs;
      step();
      check($sformatf("R%0d row%0d", VEC[i].rq, i), VEC[i].erem, VEC[i].eal, VEC[i].eld, VEC[i].euf);
      idle_inputs();
    end

    // R12: select switches with no clock edge in between
    @(posedge clk); #2;
    view_slot = 1; #1; check("R12", 64, 0, 1, 1);
    view_slot = 0; #1; check("R12", 200, 0, 1, 0);
    view_slot = 2; #1; check("R12", 0, 0, 0, 0);

    // R5 saturation: slot2 started with 0 threads, then many launches
    step();
    cta_start = 1; cta_start_slot = 2; cta_start_threads = 0; view_slot = 2;
    step();
    idle_inputs();
    check("R2", 0, 0, 1, 0);
    warp_go = 1; warp_go_slot = 2;
    for (int k = 0; k < 255; k++) step();
    check("R5", 0, 8160, 1, 0);
    step();
    check("R5", 0, 8191, 1, 0);
    step();
    check("R5", 0, 8191, 1, 0);
    idle_inputs();
    warp_quit = 1; warp_quit_slot = 2;
    step();
    idle_inputs();
    check("R6", 0, 8159, 1, 0);

    // R11: slot1 still holds its state after all of that
    view_slot = 1; #1;
    check("R11", 64, 0, 1, 1);

    // R1: reset mid-run clears everything
    step();
    reset_and_check_r1();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule